// File: doc/BRIEF.md
# Interrupt Aggregator with Message/Legacy Signalling Selection

This block gathers interrupt requests from eight mailbox sources and one level-sensitive local-bus line. It keeps a status bit and an enable bit for each of them. Every source whose status and enable bits are both set feeds a single combined pending condition. Two configuration-space control inputs decide how that condition reaches the host. In message mode it produces a one-cycle message request pulse. In legacy mode it drives a virtual INTA level and issues separate one-cycle assert and deassert message request strobes whenever that level changes.

Software services interrupts through a small register port. A status word shows which sources are pending, so software can choose which one to handle first. Mailbox bits are cleared by writing ones to the status word. The local-bus bit only mirrors its input line, so it has to be cleared at the component that raised it. A second word holds the enables. Building message packets and storing the rest of configuration space are left to neighbouring blocks.

Top module: `intr_fanin_ctl`

## Requirements
- R1: A one-cycle high on bit i of `mbox_set` sets mailbox status bit i. The bit stays set until software clears it. Mailbox status is read at bits [7:0] of the status word, address 0x40.
- R2: A write to address 0x40 clears every mailbox status bit whose `reg_wdata` bit is 1 and leaves bits written with 0 unchanged. When a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: Bit 8 of the status word is the local-bus status. It follows `lbus_irq` with a delay of one clock edge. Writing the status word does not change it.
- R4: The enable word at address 0x44 can be read and written in bits [8:0]. Enable bit i gates mailbox i (i = 0..7), and enable bit 8 gates the local-bus source. A source counts as pending only when its status bit and its enable bit are both 1.
- R5: While `cfg_msi_en` is 1, `msi_req` is high for exactly one cycle each time the combined pending condition rises from 0 to 1. It does not pulse again until the condition has fallen and risen again.
- R6: `inta_level` is the registered value of (pending AND NOT `cfg_msi_en` AND NOT `cfg_intx_off`).
- R7: `inta_msg_assert` pulses for one cycle in the same cycle that `inta_level` rises. `inta_msg_deassert` pulses for one cycle in the same cycle that `inta_level` falls.
- R8: If message mode is selected, or `cfg_intx_off` is set, while `inta_level` is high, the level drops and a deassert strobe is issued.
- R9: While `rst` is high, all status bits, all enable bits, `inta_level` and every output are cleared.
- R10: `reg_rdata` is registered from `reg_addr`. It reads 0 for any address other than 0x40 and 0x44, and bits above 8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mbox_set | input | 8 | Per-mailbox set pulses |
| lbus_irq | input | 1 | Local-bus interrupt level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (reads and writes) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cfg_msi_en | input | 1 | Message signalling enable from configuration space |
| cfg_intx_off | input | 1 | Legacy interrupt disable from configuration space |
| msi_req | output | 1 | One-cycle message interrupt request |
| inta_level | output | 1 | Virtual legacy INTA level |
| inta_msg_assert | output | 1 | Request for an assert-INTA message |
| inta_msg_deassert | output | 1 | Request for a deassert-INTA message |

## Verification
A set pulse or a register write takes effect at the edge that samples it. Its effect appears on `reg_rdata` one edge after the address is presented. A mailbox set pulse or a change on `lbus_irq` reaches `msi_req` and the INTA outputs two edges after it is driven. A change in the enables or the configuration inputs reaches them one edge after it is driven. The bench reference model advances at each rising edge using the inputs driven at the previous falling edge, and every output is compared with the model at the following falling edge. Each comparison therefore lands in exactly the cycle where these latencies put the result.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int MBOX_CNT    = 8;
    localparam int REG_DW      = 32;
    localparam int REG_AW      = 8;
    localparam logic [REG_AW-1:0] OFS_STATUS = 8'h40;
    localparam logic [REG_AW-1:0] OFS_ENABLE = 8'h44;

    typedef enum logic [1:0] {
        SIG_OFF    = 2'd0,
        SIG_LEGACY = 2'd1,
        SIG_MSG    = 2'd2
    } sig_mode_e;

    typedef struct packed {
        logic msg;
        logic level;
        logic up;
        logic down;
    } sig_out_t;

    function automatic sig_mode_e pick_mode(input logic msg_en, input logic legacy_off);
        if (msg_en)
            return SIG_MSG;
        else if (legacy_off)
            return SIG_OFF;
        else
            return SIG_LEGACY;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_agg_pkg::*;
#(
    parameter int NUM_MBOX = MBOX_CNT,
    parameter int DATA_W   = REG_DW,
    parameter int ADDR_W   = REG_AW,
    parameter logic [ADDR_W-1:0] STAT_OFS = OFS_STATUS,
    parameter logic [ADDR_W-1:0] EN_OFS   = OFS_ENABLE,
    localparam int NUM_SRC = NUM_MBOX + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_MBOX-1:0] set_pulse,
    input  logic                lbus_line,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_SRC-1:0]  stat,
    output logic [NUM_SRC-1:0]  en
);

    logic                hit_stat;
    logic                hit_en;
    logic [NUM_MBOX-1:0] mb_stat;
    logic [NUM_MBOX-1:0] clr_mask;
    logic                lb_q;
    logic [NUM_SRC-1:0]  en_q;

    assign hit_stat = wr && (addr == STAT_OFS);
    assign hit_en   = wr && (addr == EN_OFS);

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_mbox
        logic bit_q;
        assign clr_mask[g] = hit_stat && wdata[g];
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (set_pulse[g])
                bit_q <= 1'b1;
            else if (clr_mask[g])
                bit_q <= 1'b0;
        end
        assign mb_stat[g] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lb_q <= 1'b0;
            en_q <= '0;
        end else begin
            lb_q <= lbus_line;
            if (hit_en)
                en_q <= wdata[NUM_SRC-1:0];
        end
    end

    assign stat = {lb_q, mb_stat};
    assign en   = en_q;

    // R1: a set bit survives unless a clear was requested
    assert_mbox_hold_R1: assert property (@(posedge clk) disable iff (rst)
        ((mb_stat & $past(mb_stat & ~clr_mask)) == $past(mb_stat & ~clr_mask)));

    // R2: a set pulse always lands, even against a clear
    assert_set_wins_R2: assert property (@(posedge clk) disable iff (rst)
        ((mb_stat & $past(set_pulse)) == $past(set_pulse)));

    // R3: local-bus status mirrors its line, untouched by writes
    assert_lbus_mirror_R3: assert property (@(posedge clk) disable iff (rst)
        (stat[NUM_MBOX] == $past(lbus_line)));

endmodule

// File: rtl/irq_signal_ctl.sv
module irq_signal_ctl
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic msg_en,
    input  logic legacy_off,
    output logic msg_req,
    output logic level,
    output logic level_up,
    output logic level_down
);

    sig_mode_e mode;
    logic      level_nxt;
    logic      pend_q;
    sig_out_t  out_q;

    assign mode      = pick_mode(msg_en, legacy_off);
    assign level_nxt = pending && (mode == SIG_LEGACY);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            out_q  <= '0;
        end else begin
            pend_q      <= pending;
            out_q.msg   <= (mode == SIG_MSG) && pending && !pend_q;
            out_q.level <= level_nxt;
            out_q.up    <= level_nxt && !out_q.level;
            out_q.down  <= !level_nxt && out_q.level;
        end
    end

    assign msg_req    = out_q.msg;
    assign level      = out_q.level;
    assign level_up   = out_q.up;
    assign level_down = out_q.down;

    assert_msg_single_R5: assert property (@(posedge clk) disable iff (rst)
        msg_req |=> !msg_req);

    assert_msg_mode_R5: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> $past(msg_en));

    assert_legacy_off_R6: assert property (@(posedge clk) disable iff (rst)
        $past(legacy_off) |-> !level);

    assert_up_edge_R7: assert property (@(posedge clk) disable iff (rst)
        level_up |-> (level && !$past(level)));

    assert_down_edge_R7: assert property (@(posedge clk) disable iff (rst)
        level_down |-> (!level && $past(level)));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(level_up && level_down));

    assert_switch_release_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(level) && ($past(msg_en) || $past(legacy_off))) |-> level_down);

endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = MBOX_CNT + 1,
    parameter int DATA_W  = REG_DW,
    parameter int ADDR_W  = REG_AW,
    parameter logic [ADDR_W-1:0] STAT_OFS = OFS_STATUS,
    parameter logic [ADDR_W-1:0] EN_OFS   = OFS_ENABLE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SRC-1:0] stat,
    input  logic [NUM_SRC-1:0] en,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= '0;
            if (addr == STAT_OFS)
                rd_q[NUM_SRC-1:0] <= stat;
            else if (addr == EN_OFS)
                rd_q[NUM_SRC-1:0] <= en;
        end
    end

    assign rdata = rd_q;

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rdata != '0) |-> ($past(addr) == STAT_OFS || $past(addr) == EN_OFS));

endmodule

// File: rtl/intr_fanin_ctl.sv
module intr_fanin_ctl
    import irq_agg_pkg::*;
#(
    parameter int NUM_MBOX = MBOX_CNT,
    parameter int DATA_W   = REG_DW,
    parameter int ADDR_W   = REG_AW,
    parameter logic [ADDR_W-1:0] STAT_OFS = OFS_STATUS,
    parameter logic [ADDR_W-1:0] EN_OFS   = OFS_ENABLE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_MBOX-1:0] mbox_set,
    input  logic                lbus_irq,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                cfg_msi_en,
    input  logic                cfg_intx_off,
    output logic                msi_req,
    output logic                inta_level,
    output logic                inta_msg_assert,
    output logic                inta_msg_deassert
);

    localparam int NUM_SRC = NUM_MBOX + 1;

    logic [NUM_SRC-1:0] stat;
    logic [NUM_SRC-1:0] en;
    logic               pending;

    irq_src_bank #(
        .NUM_MBOX (NUM_MBOX),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .EN_OFS   (EN_OFS)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (mbox_set),
        .lbus_line (lbus_irq),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .stat      (stat),
        .en        (en)
    );

    assign pending = |(stat & en);

    irq_signal_ctl u_sig (
        .clk        (clk),
        .rst        (rst),
        .pending    (pending),
        .msg_en     (cfg_msi_en),
        .legacy_off (cfg_intx_off),
        .msg_req    (msi_req),
        .level      (inta_level),
        .level_up   (inta_msg_assert),
        .level_down (inta_msg_deassert)
    );

    irq_reg_read #(
        .NUM_SRC  (NUM_SRC),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .EN_OFS   (EN_OFS)
    ) u_rd (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .stat  (stat),
        .en    (en),
        .rdata (reg_rdata)
    );

    // R4: with no enabled pending source, no new request can appear
    assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(pending) |-> (!msi_req && !inta_msg_assert));

endmodule

// File: tb/test_intr_fanin_ctl.sv
`timescale 1ns/1ps
module test_intr_fanin_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mbox_set = '0;
    logic        lbus_irq = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cfg_msi_en = 1'b0;
    logic        cfg_intx_off = 1'b0;
    logic        msi_req, inta_level, inta_msg_assert, inta_msg_deassert;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    intr_fanin_ctl i_intr_fanin_ctl (
        .clk               (clk),
        .rst               (rst),
        .mbox_set          (mbox_set),
        .lbus_irq          (lbus_irq),
        .reg_wr            (reg_wr),
        .reg_addr          (reg_addr),
        .reg_wdata         (reg_wdata),
        .reg_rdata         (reg_rdata),
        .cfg_msi_en        (cfg_msi_en),
        .cfg_intx_off      (cfg_intx_off),
        .msi_req           (msi_req),
        .inta_level        (inta_level),
        .inta_msg_assert   (inta_msg_assert),
        .inta_msg_deassert (inta_msg_deassert)
    );

    // behavioural reference model
    bit [7:0]  m_mbox = '0;
    bit        m_lbus = 0;
    bit [8:0]  m_en = '0;
    bit        m_was_pending = 0;
    bit        m_msi = 0, m_lvl = 0, m_up = 0, m_dn = 0;
    bit [31:0] m_rd = '0;

    always @(posedge clk) begin : model
        bit        any;
        bit        want;
        bit [31:0] rd;
        if (rst) begin
            m_mbox = '0; m_lbus = 0; m_en = '0; m_was_pending = 0;
            m_msi = 0; m_lvl = 0; m_up = 0; m_dn = 0; m_rd = '0;
        end else begin
            any  = (({m_lbus, m_mbox} & m_en) != 9'd0);
            want = any && !cfg_msi_en && !cfg_intx_off;
            rd   = '0;
            if (reg_addr == 8'h40) rd[8:0] = {m_lbus, m_mbox};
            else if (reg_addr == 8'h44) rd[8:0] = m_en;
            m_msi = cfg_msi_en && any && !m_was_pending;
            m_up  = want && !m_lvl;
            m_dn  = !want && m_lvl;
            m_lvl = want;
            m_was_pending = any;
            m_rd  = rd;
            if (reg_wr && reg_addr == 8'h40) m_mbox = m_mbox & ~reg_wdata[7:0];
            m_mbox = m_mbox | mbox_set;
            if (reg_wr && reg_addr == 8'h44) m_en = reg_wdata[8:0];
            m_lbus = lbus_irq;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check("reg_rdata", reg_rdata, m_rd);
        check("msi_req", {31'd0, msi_req}, {31'd0, m_msi});
        check("inta_level", {31'd0, inta_level}, {31'd0, m_lvl});
        check("inta_msg_assert", {31'd0, inta_msg_assert}, {31'd0, m_up});
        check("inta_msg_deassert", {31'd0, inta_msg_deassert}, {31'd0, m_dn});
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a);
        reg_addr = a;
        tick(3);
    endtask

    task automatic pulse(input logic [7:0] m);
        mbox_set = m;
        tick(1);
        mbox_set = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R9: reset state
        tick(3);
        rst = 1'b0;
        rd(8'h40);
        rd(8'h44);
        // R4: enable word read/write and gating
        cur_req = "R4";
        wr(8'h44, 32'hFFFF_F155);
        rd(8'h44);
        pulse(8'h04);
        tick(3);
        wr(8'h40, 32'h0000_00FF);
        wr(8'h44, 32'h0);
        rd(8'h44);
        // R10: unmapped addresses
        cur_req = "R10";
        rd(8'h48);
        rd(8'h00);
        // R1: set and hold
        cur_req = "R1";
        reg_addr = 8'h40;
        pulse(8'h08);
        tick(4);
        pulse(8'h81);
        tick(3);
        // R2: write-one-to-clear, zeros ignored, set wins
        cur_req = "R2";
        wr(8'h40, 32'h0000_0028);
        tick(2);
        mbox_set = 8'h80;
        wr(8'h40, 32'h0000_0080);
        mbox_set = '0;
        rd(8'h40);
        wr(8'h40, 32'h0000_00FF);
        rd(8'h40);
        // R3: local-bus mirror, not cleared by writes
        cur_req = "R3";
        lbus_irq = 1'b1;
        rd(8'h40);
        wr(8'h40, 32'h0000_01FF);
        tick(3);
        lbus_irq = 1'b0;
        tick(3);
        // R6 / R7: legacy level and edge strobes
        cur_req = "R6";
        wr(8'h44, 32'h0000_0004);
        pulse(8'h04);
        tick(4);
        cur_req = "R7";
        wr(8'h40, 32'h0000_0004);
        tick(4);
        // R8: disable or mode switch while asserted
        cur_req = "R8";
        wr(8'h44, 32'h0000_0100);
        lbus_irq = 1'b1;
        tick(4);
        cfg_intx_off = 1'b1;
        tick(3);
        cfg_intx_off = 1'b0;
        tick(3);
        cfg_msi_en = 1'b1;
        tick(3);
        lbus_irq = 1'b0;
        tick(3);
        // R5: message pulses on rising pending only
        cur_req = "R5";
        wr(8'h44, 32'h0000_00FF);
        pulse(8'h01);
        tick(4);
        pulse(8'h02);
        tick(4);
        wr(8'h40, 32'h0000_0003);
        tick(3);
        pulse(8'h10);
        tick(4);
        // R9: reset in mid-run clears everything
        cur_req = "R9";
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        cfg_msi_en = 1'b0;
        rd(8'h40);
        rd(8'h44);
        tick(2);
        finish_run();
    end

endmodule